// File: doc/BRIEF.md
# Fully Associative Translation Lookaside Buffer

This block caches recent virtual-to-physical page translations. A request carries a virtual address and an access kind. The page-number field of the address is compared against every valid slot at once. When a slot matches, the physical address is formed from that slot's frame number followed by the page offset, which passes through unchanged. Hit, fault and physical address are combinational, so they are valid in the same cycle as the request.

Each slot also holds attribute bits: present, read, write and execute permission, cache-disable, referenced and modified. A match on a slot that is not present, or that lacks the permission for the access kind, raises a fault and gives no translation. Successful reads and writes mark the slot as referenced. Successful writes also mark it as modified.

After a miss, an outside agent such as a table walker or software supplies the missing translation through the fill port. The fill goes into the lowest free slot if there is one. When all slots are in use, a rotating pointer picks the slot. A flush input empties the whole buffer in one cycle.

Top module: `xl_tlb`

## Requirements
- R1: After reset no slot is valid, so every lookup returns hit=0, fault=0 and paddr=0.
- R2: With req_valid high and a valid slot whose page number equals req_vaddr[VA_W-1:12], hit is 1 in the same cycle. If the access is allowed, paddr is {slot frame number, req_vaddr[11:0]}. On a miss, hit, fault, paddr and nocache are all 0.
- R3: A hit on a slot whose present flag (fill_flags bit 0) is clear gives fault=1 and paddr=0.
- R4: req_kind is encoded as 0=read, 1=write, 2=execute, 3=reserved. A hit faults when the permission for the kind is clear: read is fill_flags bit 1, write is bit 2, execute is bit 3. Kind 3 always faults.
- R5: A non-faulting read or write hit sets the slot's referenced flag, visible on hit_ref from the next cycle. Execute hits and faulting hits leave it unchanged. hit_ref shows the flag as it was before the current access.
- R6: Only a non-faulting write hit sets the slot's modified flag, shown on hit_mod.
- R7: A fill is written on the next clock edge, so a lookup in the same cycle still sees the old contents. While any slot is invalid, the lowest-numbered invalid slot is the one filled.
- R8: When all slots are valid, a fill of a new page goes to the slot named by a rotating pointer. The pointer is 0 after reset and advances by one, wrapping, after each such fill.
- R9: A fill whose page number already sits in a valid slot overwrites that slot and does not move the pointer, so no page is ever held twice.
- R10: flush clears every valid flag on the next edge. A fill in the same cycle is dropped. The rotating pointer keeps its value.
- R11: nocache equals the cache-disable flag (fill_flags bit 4) of the slot on a non-faulting hit, and is 0 otherwise.
- R12: A fill clears the referenced and modified flags of the slot it writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate every slot |
| req_valid | input | 1 | Lookup request present |
| req_vaddr | input | VPN_W+PAGE_BITS | Virtual address |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| hit | output | 1 | A valid slot matches the page number |
| fault | output | 1 | Matched slot is absent or forbids the access |
| paddr | output | PFN_W+PAGE_BITS | Translated physical address |
| nocache | output | 1 | Matched page must bypass caches |
| hit_ref | output | 1 | Referenced flag of the matched slot |
| hit_mod | output | 1 | Modified flag of the matched slot |
| fill_valid | input | 1 | Write a translation |
| fill_vpn | input | VPN_W | Page number to install |
| fill_pfn | input | PFN_W | Frame number to install |
| fill_flags | input | 5 | bit0 present, bit1 read, bit2 write, bit3 execute, bit4 cache-disable |

## Verification
Lookup results are due in the cycle of the request. The bench drives each request just after a falling edge and samples one nanosecond later, before the next rising edge. Fills, flushes and flag updates take effect at the following rising edge, so their consequences are read by a lookup in a later cycle. One check deliberately looks up a page in the very cycle its fill is presented, to confirm it still misses there. Placement of fills is observed only through which pages hit and miss afterwards.

// File: rtl/xl_tlb_pkg.sv
package xl_tlb_pkg;
  // packed so that pres lands on bit 0 and cdis on bit 4
  typedef struct packed {
    logic cdis;
    logic x;
    logic w;
    logic r;
    logic pres;
  } xl_perm_t;

  typedef enum logic [1:0] {
    ACC_RD  = 2'd0,
    ACC_WR  = 2'd1,
    ACC_EX  = 2'd2,
    ACC_RSV = 2'd3
  } xl_acc_t;
endpackage

// File: rtl/xl_tlb_entry.sv
module xl_tlb_entry
  import xl_tlb_pkg::*;
#(
  parameter int VPN_W = 20,
  parameter int PFN_W = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             wr_en,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [PFN_W-1:0] wr_pfn,
  input  xl_perm_t         wr_perm,
  input  logic             touch_rd,
  input  logic             touch_wr,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [VPN_W-1:0] fl_vpn,
  output logic             lk_match,
  output logic             fl_match,
  output logic             o_valid,
  output logic [PFN_W-1:0] o_pfn,
  output xl_perm_t         o_perm,
  output logic             o_ref,
  output logic             o_mod
);
  logic [VPN_W-1:0] vpn_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      o_valid <= 1'b0;
      o_ref   <= 1'b0;
      o_mod   <= 1'b0;
    end else if (flush) begin
      o_valid <= 1'b0;
    end else if (wr_en) begin
      o_valid <= 1'b1;
      o_ref   <= 1'b0;
      o_mod   <= 1'b0;
    end else begin
      if (touch_rd || touch_wr) o_ref <= 1'b1;
      if (touch_wr)             o_mod <= 1'b1;
    end
  end

  // payload fields carry no reset, like a RAM word
  always_ff @(posedge clk) begin
    if (wr_en && !flush) begin
      vpn_q  <= wr_vpn;
      o_pfn  <= wr_pfn;
      o_perm <= wr_perm;
    end
  end

  assign lk_match = o_valid && (vpn_q == lk_vpn);
  assign fl_match = o_valid && (vpn_q == fl_vpn);

  // modified implies referenced: both are only ever set by a write hit together
  assert_mod_has_ref_R6: assert property (@(posedge clk) disable iff (rst)
    o_mod |-> o_ref);
endmodule

// File: rtl/xl_tlb_victim.sv
module xl_tlb_victim #(
  parameter int N     = 8,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     valid_vec,
  input  logic             alloc,
  output logic [IDX_W-1:0] victim
);
  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] first_free;
  logic             any_free;

  always_comb begin
    first_free = '0;
    any_free   = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        first_free = IDX_W'(i);
        any_free   = 1'b1;
      end
    end
  end

  assign victim = any_free ? first_free : ptr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (alloc && !any_free) begin
      ptr_q <= (ptr_q == IDX_W'(N - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  assert_rr_moves_R8: assert property (@(posedge clk) disable iff (rst)
    (alloc && !any_free) |=> (ptr_q != $past(ptr_q)));
  assert_rr_holds_R9: assert property (@(posedge clk) disable iff (rst)
    !alloc |=> $stable(ptr_q));
endmodule

// File: rtl/xl_tlb.sv
module xl_tlb
  import xl_tlb_pkg::*;
#(
  parameter int N         = 8,
  parameter int VPN_W     = 20,
  parameter int PFN_W     = 18,
  parameter int PAGE_BITS = 12
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       flush,
  input  logic                       req_valid,
  input  logic [VPN_W+PAGE_BITS-1:0] req_vaddr,
  input  logic [1:0]                 req_kind,
  output logic                       hit,
  output logic                       fault,
  output logic [PFN_W+PAGE_BITS-1:0] paddr,
  output logic                       nocache,
  output logic                       hit_ref,
  output logic                       hit_mod,
  input  logic                       fill_valid,
  input  logic [VPN_W-1:0]           fill_vpn,
  input  logic [PFN_W-1:0]           fill_pfn,
  input  logic [4:0]                 fill_flags
);
  localparam int VA_W  = VPN_W + PAGE_BITS;
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [VPN_W-1:0]     lk_vpn;
  logic [PAGE_BITS-1:0] lk_off;
  logic [N-1:0]         match_vec, fmatch_vec, valid_vec, wr_vec;
  logic [N-1:0]         ref_vec, mod_vec, trd_vec, twr_vec;
  logic [PFN_W-1:0]     e_pfn [N];
  xl_perm_t             e_perm [N];
  logic [PFN_W-1:0]     sel_pfn;
  xl_perm_t             sel_perm;
  logic                 sel_ref, sel_mod, allowed, good, dup, fill_ok;
  logic [IDX_W-1:0]     victim;
  xl_acc_t              kind;

  assign lk_vpn  = req_vaddr[VA_W-1:PAGE_BITS];
  assign lk_off  = req_vaddr[PAGE_BITS-1:0];
  assign kind    = xl_acc_t'(req_kind);
  assign dup     = |fmatch_vec;
  assign fill_ok = fill_valid && !flush;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_slot
      assign wr_vec[g]  = fill_ok && (dup ? fmatch_vec[g] : (victim == IDX_W'(g)));
      assign trd_vec[g] = good && match_vec[g] && (kind == ACC_RD);
      assign twr_vec[g] = good && match_vec[g] && (kind == ACC_WR);
      xl_tlb_entry #(.VPN_W(VPN_W), .PFN_W(PFN_W)) i_entry (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .wr_en    (wr_vec[g]),
        .wr_vpn   (fill_vpn),
        .wr_pfn   (fill_pfn),
        .wr_perm  (xl_perm_t'(fill_flags)),
        .touch_rd (trd_vec[g]),
        .touch_wr (twr_vec[g]),
        .lk_vpn   (lk_vpn),
        .fl_vpn   (fill_vpn),
        .lk_match (match_vec[g]),
        .fl_match (fmatch_vec[g]),
        .o_valid  (valid_vec[g]),
        .o_pfn    (e_pfn[g]),
        .o_perm   (e_perm[g]),
        .o_ref    (ref_vec[g]),
        .o_mod    (mod_vec[g])
      );
    end
  endgenerate

  xl_tlb_victim #(.N(N), .IDX_W(IDX_W)) i_victim (
    .clk       (clk),
    .rst       (rst),
    .valid_vec (valid_vec),
    .alloc     (fill_ok && !dup),
    .victim    (victim)
  );

  // at most one slot matches, so an OR of masked fields is the selected slot
  always_comb begin
    sel_pfn  = '0;
    sel_perm = '0;
    for (int i = 0; i < N; i++) begin
      sel_pfn  = sel_pfn  | ({PFN_W{match_vec[i]}} & e_pfn[i]);
      sel_perm = sel_perm | ({5{match_vec[i]}} & e_perm[i]);
    end
    sel_ref = |(match_vec & ref_vec);
    sel_mod = |(match_vec & mod_vec);
  end

  always_comb begin
    case (kind)
      ACC_RD:  allowed = sel_perm.r;
      ACC_WR:  allowed = sel_perm.w;
      ACC_EX:  allowed = sel_perm.x;
      default: allowed = 1'b0;
    endcase
    allowed = allowed && sel_perm.pres;
  end

  assign hit     = req_valid && (|match_vec);
  assign good    = hit && allowed;
  assign fault   = hit && !allowed;
  assign paddr   = good ? {sel_pfn, lk_off} : '0;
  assign nocache = good && sel_perm.cdis;
  assign hit_ref = hit && sel_ref;
  assign hit_mod = hit && sel_mod;

  assert_single_match_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match_vec));
  assert_one_write_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_vec));
  assert_flush_empties_R10: assert property (@(posedge clk) disable iff (rst)
    flush |=> (valid_vec == '0));
  assert_fault_needs_hit_R3: assert property (@(posedge clk) disable iff (rst)
    fault |-> hit);
  assert_miss_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !hit |-> (paddr == '0 && !nocache && !hit_ref));
  assert_fill_lands_R7: assert property (@(posedge clk) disable iff (rst)
    fill_ok |=> (valid_vec != '0));
endmodule

// File: tb/test_xl_tlb.sv
`timescale 1ns/1ps
module test_xl_tlb;
  localparam int N = 8, VPN_W = 20, PFN_W = 18, PB = 12;
  localparam int VA_W = VPN_W + PB, PA_W = PFN_W + PB;

  logic clk = 0, rst = 1, flush = 0, req_valid = 0, fill_valid = 0;
  logic [VA_W-1:0] req_vaddr = '0;
  logic [1:0] req_kind = 0;
  logic [VPN_W-1:0] fill_vpn = '0;
  logic [PFN_W-1:0] fill_pfn = '0;
  logic [4:0] fill_flags = '0;
  logic hit, fault, nocache, hit_ref, hit_mod;
  logic [PA_W-1:0] paddr;
  int n_vec = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  xl_tlb #(.N(N), .VPN_W(VPN_W), .PFN_W(PFN_W), .PAGE_BITS(PB)) i_xl_tlb (
    .clk(clk), .rst(rst), .flush(flush), .req_valid(req_valid),
    .req_vaddr(req_vaddr), .req_kind(req_kind), .hit(hit), .fault(fault),
    .paddr(paddr), .nocache(nocache), .hit_ref(hit_ref), .hit_mod(hit_mod),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
    .fill_flags(fill_flags));

  // {vaddr[32], kind[2], hit, fault, paddr[30]}
  localparam logic [65:0] VEC [9] = '{
    {32'h00010ABC, 2'd0, 1'b1, 1'b0, 30'h00A01ABC},
    {32'h00010ABC, 2'd1, 1'b1, 1'b1, 30'h0},
    {32'h00020FFF, 2'd1, 1'b1, 1'b0, 30'h00B02FFF},
    {32'h00030000, 2'd2, 1'b1, 1'b0, 30'h00C03000},
    {32'h00030000, 2'd0, 1'b1, 1'b1, 30'h0},
    {32'h00040123, 2'd0, 1'b1, 1'b1, 30'h0},
    {32'h00050001, 2'd0, 1'b1, 1'b0, 30'h3FFFF001},
    {32'h00060001, 2'd0, 1'b0, 1'b0, 30'h0},
    {32'h00020000, 2'd3, 1'b1, 1'b1, 30'h0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic look(input logic [31:0] va, input logic [1:0] k);
    @(negedge clk);
    req_valid = 1; req_vaddr = va; req_kind = k;
    #1;
  endtask

  task automatic fill(input logic [19:0] v, input logic [17:0] p, input logic [4:0] f);
    @(negedge clk);
    req_valid = 0;
    fill_valid = 1; fill_vpn = v; fill_pfn = p; fill_flags = f;
    @(negedge clk);
    fill_valid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++; n_vec++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1
    look(32'h12345678, 0);
    chk("R1 hit", hit, 0); chk("R1 fault", fault, 0); chk("R1 paddr", paddr, 0);

    fill(20'h00010, 18'h00A01, 5'b00011);
    fill(20'h00020, 18'h00B02, 5'b00111);
    fill(20'h00030, 18'h00C03, 5'b01001);
    fill(20'h00040, 18'h00D04, 5'b00110);
    fill(20'h00050, 18'h3FFFF, 5'b10111);

    // R2 R3 R4 vector walk
    foreach (VEC[i]) begin
      look(VEC[i][65:34], VEC[i][33:32]);
      chk($sformatf("R2/R3/R4 vec%0d hit", i), hit, VEC[i][31]);
      chk($sformatf("R2/R3/R4 vec%0d fault", i), fault, VEC[i][30]);
      chk($sformatf("R2/R3/R4 vec%0d paddr", i), paddr, VEC[i][29:0]);
    end

    // R5 R6 flags after the walk
    look(32'h00030000, 2); chk("R5 exec leaves ref", hit_ref, 0);
    look(32'h00010000, 0); chk("R5 read sets ref", hit_ref, 1);
    chk("R6 read leaves mod", hit_mod, 0);
    look(32'h00020000, 0); chk("R6 write sets mod", hit_mod, 1);
    chk("R5 write sets ref", hit_ref, 1);
    look(32'h00040000, 0); chk("R5 fault leaves ref", hit_ref, 0);
    // R11
    look(32'h00050000, 0); chk("R11 nocache set", nocache, 1);
    look(32'h00010000, 0); chk("R11 nocache clear", nocache, 0);
    look(32'h00040000, 1); chk("R11 nocache on fault", nocache, 0);

    // R9 R12 refill of a resident page
    fill(20'h00010, 18'h00111, 5'b00111);
    look(32'h00010000, 0);
    chk("R9 overwrite paddr", paddr, 32'h00111000);
    chk("R12 ref cleared", hit_ref, 0); chk("R12 mod cleared", hit_mod, 0);

    fill(20'h00070, 18'h1, 5'b00011);
    fill(20'h00080, 18'h2, 5'b00011);
    fill(20'h00090, 18'h3, 5'b00011);
    // R8 full: pointer at 0
    fill(20'h000A0, 18'h4, 5'b00011);
    look(32'h00010000, 0); chk("R8 slot0 replaced", hit, 0);
    look(32'h00020000, 0); chk("R8 slot1 kept", hit, 1);
    fill(20'h000B0, 18'h5, 5'b00011);
    look(32'h00020000, 0); chk("R8 slot1 replaced", hit, 0);
    look(32'h00030000, 2); chk("R8 slot2 kept", hit, 1);
    look(32'h000A0000, 0); chk("R8 new page", hit, 1);

    // R10 flush beats fill
    @(negedge clk);
    req_valid = 0; flush = 1; fill_valid = 1; fill_vpn = 20'h000C0;
    fill_pfn = 18'h6; fill_flags = 5'b00011;
    @(negedge clk);
    flush = 0; fill_valid = 0;
    look(32'h00030000, 2); chk("R10 flushed", hit, 0);
    look(32'h000A0000, 0); chk("R10 flushed", hit, 0);
    look(32'h000C0000, 0); chk("R10 fill dropped", hit, 0);

    // R7 fill lands on next edge, lowest free slots first
    @(negedge clk);
    fill_valid = 1; fill_vpn = 20'h00100; fill_pfn = 18'h100; fill_flags = 5'b00011;
    req_valid = 1; req_vaddr = 32'h00100000; req_kind = 0;
    #1; chk("R7 same cycle miss", hit, 0);
    @(negedge clk);
    fill_valid = 0; #1;
    chk("R7 next cycle hit", hit, 1);
    for (int k = 1; k < 8; k++) fill(20'h00100 + k, 18'h100 + k, 5'b00011);
    fill(20'h00108, 18'h108, 5'b00011);
    look(32'h00102000, 0); chk("R8 pointer kept at 2 after flush", hit, 0);
    look(32'h00100000, 0); chk("R7 slot0 kept", hit, 1);
    look(32'h00103000, 0); chk("R7 slot3 kept", hit, 1);
    look(32'h00108ABC, 0); chk("R7 new paddr", paddr, 32'h00108ABC);

    @(negedge clk);
    req_valid = 0;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule